// File: doc/BRIEF.md
# Multi-Valued Parameter Address Mapper

Some network parameters, such as node admittances and equivalent conductances, can take only a few precomputed values, and which value applies depends on the switches that are currently open or closed. The possible values sit side by side in a parameter memory. This block finds the address of the value that is in force now. An instruction supplies a guide-word address. The block reads that guide word from a local table. The guide word names a base address, three influencing-word locations and a decode mode.

The three influencing words are kept in separate groups: non-linear, fast time-varying and slow time-varying. Each group has its own table. The block ORs the three selected words into one combined word and decodes it into an offset. It then adds the offset to the base address.

There are two decode modes. In count mode, the combined word holds two switch-class fields. Every switch in a class shares one pair of admittance values, so only the number of closed switches in each class matters, and the offset is built from those two counts. In raw mode, one field is used directly as the offset. The block accepts one request per clock and returns each address exactly three cycles later.

Top module: `mvp_addr_map`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, out_valid is 0 and out_addr is 0.
- R2: A request sampled with req_valid high at a rising edge produces out_valid high after the third rising edge that follows. Requests may arrive on every cycle, and results come out in request order.
- R3: A guide-word write (gw_we) stores gw_wdata at gw_waddr. The field layout is: base [15:0], non-linear index [21:16], fast index [27:22], slow index [33:28], mode [34] (0 count, 1 raw), field-1 position [38:35], field-1 width [43:39], field-2 position [47:44], field-2 width [52:48]. A request issued in the cycle after the write uses the new word.
- R4: The combined word is the bitwise OR of the non-linear group entry, the fast group entry and the slow group entry that the guide word names.
- R5: In count mode, offset = n1*(w2+1) + n2. Here n1 and n2 are the numbers of set bits in field 1 and field 2 of the combined word, and w2 is the width of field 2.
- R6: In raw mode, the offset is field 1 of the combined word, shifted down to bit 0.
- R7: out_addr = base + offset, modulo 2^16.
- R8: An influencing-word write (iw_we) stores iw_wdata into group iw_grp (0 non-linear, 1 fast, 2 slow) at iw_waddr, and leaves the other groups unchanged. A request issued in the same cycle as the write, or any later cycle, sees the new value. iw_grp = 3 writes nothing.
- R9: In cycles where out_valid is low, out_addr keeps its previous value.
- R10: A field takes the bits from its position upward, up to bit 15. A width of 0 gives an empty field. A width of 16 or more keeps every bit from the position upward, and count mode then uses 16 as w2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gw_we | input | 1 | Guide-word write enable |
| gw_waddr | input | 6 | Guide-word table index |
| gw_wdata | input | 53 | Guide word to store |
| iw_we | input | 1 | Influencing-word write enable |
| iw_grp | input | 2 | Influencing-word group select |
| iw_waddr | input | 6 | Influencing-word index within group |
| iw_wdata | input | 16 | Influencing word to store |
| req_valid | input | 1 | Request strobe |
| req_gaddr | input | 6 | Guide-word address of the request |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 16 | Address of the current parameter value |

## Verification
The hardest case to reach from the ports is an influencing-word write that lands on the same clock as a request that reads the same entry. This case separates a design that fetches the words in the second stage from one that fetches them early. The random phase issues requests and writes together on most cycles, using a small set of indices so that collisions happen often. It also rewrites guide words while they are being read. The directed cases then cover empty fields, widths of 16 or more, fields that run past bit 15, and keeping the groups separate.

// File: rtl/mvp_addr_map.sv
module mvp_addr_map #(
  parameter int IW_W   = 16,
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gw_we,
  input  logic [$clog2(DEPTH)-1:0] gw_waddr,
  input  logic [ADDR_W+3*$clog2(DEPTH)+1+2*($clog2(IW_W)+$clog2(IW_W+1))-1:0] gw_wdata,
  input  logic                iw_we,
  input  logic [1:0]          iw_grp,
  input  logic [$clog2(DEPTH)-1:0] iw_waddr,
  input  logic [IW_W-1:0]     iw_wdata,
  input  logic                req_valid,
  input  logic [$clog2(DEPTH)-1:0] req_gaddr,
  output logic                out_valid,
  output logic [ADDR_W-1:0]   out_addr
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(IW_W);
  localparam int WW = $clog2(IW_W + 1);
  localparam int GW = ADDR_W + 3*AW + 1 + 2*(PW + WW);
  localparam int O_NL = ADDR_W;
  localparam int O_FA = O_NL + AW;
  localparam int O_SL = O_FA + AW;
  localparam int O_MD = O_SL + AW;
  localparam int O_P1 = O_MD + 1;
  localparam int O_W1 = O_P1 + PW;
  localparam int O_P2 = O_W1 + WW;
  localparam int O_W2 = O_P2 + PW;

  logic [GW-1:0]   gtab [DEPTH];
  logic [IW_W-1:0] iwt  [3][DEPTH];

  logic            v1, v2;
  logic [GW-1:0]   g1, g2;
  logic [IW_W-1:0] comb2;

  always_ff @(posedge clk) begin
    if (gw_we) gtab[gw_waddr] <= gw_wdata;
  end

  for (genvar k = 0; k < 3; k++) begin : g_grp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) iwt[k][i] <= '0;
      end else if (iw_we && iw_grp == 2'(k)) begin
        iwt[k][iw_waddr] <= iw_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      g1 <= '0;
      g2 <= '0;
      comb2 <= '0;
    end else begin
      v1 <= req_valid;
      if (req_valid) g1 <= gtab[req_gaddr];
      v2 <= v1;
      if (v1) begin
        g2    <= g1;
        comb2 <= iwt[0][g1[O_NL +: AW]] | iwt[1][g1[O_FA +: AW]] | iwt[2][g1[O_SL +: AW]];
      end
    end
  end

  function automatic logic [IW_W-1:0] field(input logic [IW_W-1:0] w,
                                            input logic [PW-1:0] pos,
                                            input logic [WW-1:0] wid);
    logic [IW_W-1:0] mask;
    mask = ~({IW_W{1'b1}} << wid);
    return (w >> pos) & mask;
  endfunction

  logic            mode2;
  logic [WW-1:0]   wid1, wid2;
  logic [IW_W-1:0] f1, f2;
  logic [ADDR_W-1:0] n1, n2, w1e, w2e, off;

  assign mode2 = g2[O_MD];
  assign wid1  = g2[O_W1 +: WW];
  assign wid2  = g2[O_W2 +: WW];
  assign f1    = field(comb2, g2[O_P1 +: PW], wid1);
  assign f2    = field(comb2, g2[O_P2 +: PW], wid2);
  assign n1    = ADDR_W'($countones(f1));
  assign n2    = ADDR_W'($countones(f2));
  assign w1e   = (int'(wid1) > IW_W) ? ADDR_W'(IW_W) : ADDR_W'(wid1);
  assign w2e   = (int'(wid2) > IW_W) ? ADDR_W'(IW_W) : ADDR_W'(wid2);
  assign off   = mode2 ? ADDR_W'(f1) : n1 * (w2e + 1'b1) + n2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= v2;
      if (v2) out_addr <= g2[ADDR_W-1:0] + off;
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(req_valid, 3));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_addr));

  p_raw_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && mode2 && int'(wid1) < IW_W) |-> ((off >> wid1) == '0));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && !mode2) |-> (n1 <= w1e && n2 <= w2e && off <= w1e * (w2e + 1'b1) + w2e));

  p_reset_r1: assert property (@(posedge clk)
    !$past(rst_n) |-> (!out_valid && out_addr == '0));
endmodule

// File: tb/test_mvp_addr_map.sv
module test_mvp_addr_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gw_we = 1'b0;
  logic [5:0]  gw_waddr = '0;
  logic [52:0] gw_wdata = '0;
  logic        iw_we = 1'b0;
  logic [1:0]  iw_grp = '0;
  logic [5:0]  iw_waddr = '0;
  logic [15:0] iw_wdata = '0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_gaddr = '0;
  logic        out_valid;
  logic [15:0] out_addr;

  mvp_addr_map i_mvp_addr_map (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [52:0] m_gw [64];
  logic [15:0] m_iw [3][64];
  bit          hv [3];
  logic [15:0] ha [3];
  logic [15:0] last_addr = '0;

  function automatic logic [52:0] pack(int base, int nl, int fa, int sl, int md,
                                       int p1, int w1, int p2, int w2);
    logic [52:0] g;
    g = '0;
    g[15:0] = 16'(base); g[21:16] = 6'(nl); g[27:22] = 6'(fa); g[33:28] = 6'(sl);
    g[34] = 1'(md); g[38:35] = 4'(p1); g[43:39] = 5'(w1);
    g[47:44] = 4'(p2); g[52:48] = 5'(w2);
    return g;
  endfunction

  function automatic int fcount(logic [15:0] w, int p, int wd);
    int c = 0;
    for (int i = p; i < p + wd && i < 16; i++) c += w[i];
    return c;
  endfunction

  function automatic int fvalue(logic [15:0] w, int p, int wd);
    int v = 0;
    for (int i = p; i < p + wd && i < 16; i++) if (w[i]) v += (1 << (i - p));
    return v;
  endfunction

  function automatic logic [15:0] f_exp(int ga);
    logic [52:0] g;
    logic [15:0] c;
    int p1, w1, p2, w2, off;
    g  = m_gw[ga];
    c  = m_iw[0][g[21:16]] | m_iw[1][g[27:22]] | m_iw[2][g[33:28]];
    p1 = int'(g[38:35]); w1 = int'(g[43:39]);
    p2 = int'(g[47:44]); w2 = int'(g[52:48]);
    if (g[34]) off = fvalue(c, p1, w1);
    else off = fcount(c, p1, w1) * ((w2 > 16 ? 16 : w2) + 1) + fcount(c, p2, w2);
    return 16'(int'(g[15:0]) + off);
  endfunction

  task automatic check(bit cond, string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drives at negedge, then checks after the next edge
  task automatic cyc(bit gwe, int gwa, logic [52:0] gwd,
                     bit iwe, int igp, int iwa, logic [15:0] iwd,
                     bit rv, int ra, string tag);
    logic [15:0] e;
    gw_we = gwe; gw_waddr = 6'(gwa); gw_wdata = gwd;
    iw_we = iwe; iw_grp = 2'(igp); iw_waddr = 6'(iwa); iw_wdata = iwd;
    req_valid = rv; req_gaddr = 6'(ra);
    if (iwe && igp < 3) m_iw[igp][iwa] = iwd;
    e = rv ? f_exp(ra) : '0;
    if (gwe) m_gw[gwa] = gwd;
    hv[2] = hv[1]; ha[2] = ha[1]; hv[1] = hv[0]; ha[1] = ha[0];
    hv[0] = rv; ha[0] = e;
    @(posedge clk); @(negedge clk);
    if (hv[2]) begin
      check(out_valid === 1'b1, {tag, " R2 valid"}, 16'(out_valid), 16'd1);
      check(out_addr === ha[2], {tag, " R5/R6/R7 addr"}, out_addr, ha[2]);
      last_addr = ha[2];
    end else begin
      check(out_valid === 1'b0, {tag, " R2 idle"}, 16'(out_valid), 16'd0);
      check(out_addr === last_addr, {tag, " R9 hold"}, out_addr, last_addr);
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, 0, 0, 0, '0, 0, 0, tag);
  endtask

  task automatic wiw(int g, int a, logic [15:0] d);
    cyc(0, 0, '0, 1, g, a, d, 0, 0, "wiw");
  endtask

  task automatic wgw(int a, logic [52:0] d);
    cyc(1, a, d, 0, 0, 0, '0, 0, 0, "wgw");
  endtask

  task automatic req(int a, string tag);
    cyc(0, 0, '0, 0, 0, 0, '0, 1, a, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin
      m_gw[i] = '0;
      for (int k = 0; k < 3; k++) m_iw[k][i] = '0;
    end
    for (int i = 0; i < 3; i++) begin hv[i] = 0; ha[i] = '0; end
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_addr === 16'd0, "R1 reset", out_addr, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && out_addr === 16'd0, "R1 after reset", out_addr, 16'd0);

    for (int i = 0; i < 64; i++) wgw(i, '0);

    // R4 R5: count mode, fields 4 bits at 0 and 4 bits at 8
    wiw(0, 1, 16'h0003); wiw(1, 2, 16'h0100); wiw(2, 3, 16'h0304);
    wgw(5, pack(16'h1000, 1, 2, 3, 0, 0, 4, 8, 4));
    req(5, "R5 count");
    idle(3, "R5 drain");
    // R6 raw
    wgw(6, pack(16'h2000, 1, 2, 3, 1, 2, 5, 0, 0));
    req(6, "R6 raw");
    // R10 full width, zero width, field running past bit 15
    wgw(7, pack(16'h0010, 1, 2, 3, 0, 0, 16, 0, 20));
    wgw(8, pack(16'h0020, 1, 2, 3, 1, 0, 0, 0, 0));
    wgw(9, pack(16'h0030, 1, 2, 3, 1, 12, 9, 0, 0));
    req(7, "R10 full"); req(8, "R10 empty"); req(9, "R10 clip");
    idle(3, "R10 drain");
    // R7 wrap
    wiw(0, 10, 16'hffff);
    wgw(10, pack(16'hfff0, 10, 0, 0, 1, 0, 16, 0, 0));
    req(10, "R7 wrap");
    idle(3, "R7 drain");
    // R8 group separation and ignored group 3
    wiw(1, 10, 16'h00f0);
    wiw(3, 10, 16'h0f00);
    req(10, "R8 groups");
    // R8 same-cycle write visible; R3 guide written previous cycle
    wgw(11, pack(16'h0400, 11, 11, 11, 1, 0, 16, 0, 0));
    cyc(0, 0, '0, 1, 2, 11, 16'h5a5a, 1, 11, "R8 same cycle");
    req(11, "R3 guide");
    idle(3, "R8 drain");

    // random phase with frequent collisions
    for (int n = 0; n < 2000; n++) begin
      bit gwe = ($urandom % 8) == 0;
      bit iwe = ($urandom % 2) == 0;
      logic [52:0] g = pack($urandom, $urandom % 4, $urandom % 4, $urandom % 4,
                            $urandom % 2, $urandom % 16, $urandom % 21,
                            $urandom % 16, $urandom % 21);
      cyc(gwe, $urandom % 4, g, iwe, $urandom % 4, $urandom % 4, 16'($urandom),
          ($urandom % 4) != 0, $urandom % 4, "R4 R8 random");
    end
    idle(4, "final drain");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule